// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block keeps the pointers and element counters for one DMA channel. Software programs a source start address, a destination start address, a source size and a destination size, and writes an 8-bit control byte. Each side then follows its own addressing mode. Every accepted transfer-done pulse moves both pointers and counts both counters down. When a side's counter runs out, that side goes back to its start address and its full size.

A separate stop bit on each side can drop the trigger enable when that side reloads. A channel programmed this way runs exactly one buffer pass and then stops. The source memory region code from the control byte is presented beside the addresses, so the bus logic knows which memory the source pointer refers to. Bus reads and writes, arbitration and trigger selection are left to neighbouring blocks.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset, the control byte, both pointers, both counters, both start and size registers, the trigger enable and both reload flags are all 0.
- R2: The control byte written through select 0 is decoded by bit position:
  - bit 0: source stop.
  - bits 2:1: source mode.
  - bits 4:3: source region.
  - bit 5: destination stop.
  - bits 7:6: destination mode.
- R3: On an accepted transfer that does not reload a side, that side's pointer changes according to its 2-bit mode:
  - 00 keeps the pointer.
  - 01 adds one.
  - 10 subtracts one.
  - 11 keeps the pointer, the same as 00.
- R4: Pointer arithmetic wraps modulo 2^16, so 0xFFFF plus one gives 0x0000 and 0x0000 minus one gives 0xFFFF.
- R5: On an accepted transfer, a side whose counter holds 1 or 0 reloads:
  - its counter returns to its size and its pointer returns to its start address, on the same edge and without stepping.
  - otherwise its counter drops by one.
  - a size of 0 therefore reloads on every transfer.
- R6: Each side's reload flag is high for exactly the one cycle after the edge on which that side reloaded, and is low otherwise.
- R7: The trigger enable clears on a reload in either of two cases:
  - the source reloads while its stop bit is 1.
  - the destination reloads while its stop bit is 1.
  - a reload whose stop bit is 0 leaves the trigger enable unchanged.
- R8: The source region output maps the control byte's region field as follows:
  - 00 gives code 00 (general data space).
  - 01 gives code 01 (program flash).
  - 10 and 11 both give code 10 (data EEPROM).
- R9: The write selects are:
  - 1: source start.
  - 2: destination start.
  - 3: source size.
  - 4: destination size.
  - 5: trigger enable, taken from data bit 0.
  - writing a start or size register reloads that side's pointer to its start and its counter to its size, visible after the next edge.
- R10: A transfer-done pulse is ignored, leaving pointers, counters and flags unchanged, when the trigger enable is 0 or when a write happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 16 | Write data |
| xfer_done | input | 1 | One pulse per completed transfer |
| src_addr | output | 16 | Current source pointer |
| dst_addr | output | 16 | Current destination pointer |
| src_left | output | 16 | Source elements remaining |
| dst_left | output | 16 | Destination elements remaining |
| src_region | output | 2 | Source memory region code |
| src_reload | output | 1 | Source reloaded on the last edge |
| dst_reload | output | 1 | Destination reloaded on the last edge |
| trig_en | output | 1 | Trigger enable |

## Verification
The assertions check the following on every cycle:
- a reloading side really sits at its start address with its full count.
- a reload flag only follows a transfer pulse.
- a stop bit that was set really drops the trigger enable.
- a held pointer does not move.
- nothing changes while the channel is idle.
- region code 11 never appears.

Only the bench's scenarios can show that each mode steps in the right direction, that the pointers wrap at the 16-bit boundary, and that a reload lands on exactly the right transfer for sizes of 0, 2, 3 and 5. The scenarios also cover the effect of a write colliding with a transfer pulse.

// File: rtl/dma_addr_seq.sv
module dma_addr_seq #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [2:0]                        wr_sel,
  input  logic [((AW > CW) ? AW : CW)-1:0]  wr_data,
  input  logic                              xfer_done,
  output logic [AW-1:0]                     src_addr,
  output logic [AW-1:0]                     dst_addr,
  output logic [CW-1:0]                     src_left,
  output logic [CW-1:0]                     dst_left,
  output logic [1:0]                        src_region,
  output logic                              src_reload,
  output logic                              dst_reload,
  output logic                              trig_en
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [7:0]    ctl;
  logic [AW-1:0] s_start, d_start;
  logic [CW-1:0] s_size, d_size;

  wire [1:0] s_mode = ctl[2:1];
  wire [1:0] d_mode = ctl[7:6];
  wire       s_stop = ctl[0];
  wire       d_stop = ctl[5];

  wire go     = xfer_done && trig_en && !wr_en;
  wire s_wrap = src_left <= ONE;
  wire d_wrap = dst_left <= ONE;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic [1:0] m);
    case (m)
      2'b01:   step = p + AW'(1);
      2'b10:   step = p - AW'(1);
      default: step = p;
    endcase
  endfunction

  assign src_region = ctl[4] ? 2'b10 : {1'b0, ctl[3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl        <= '0;
      s_start    <= '0;
      d_start    <= '0;
      s_size     <= '0;
      d_size     <= '0;
      src_addr   <= '0;
      dst_addr   <= '0;
      src_left   <= '0;
      dst_left   <= '0;
      src_reload <= 1'b0;
      dst_reload <= 1'b0;
      trig_en    <= 1'b0;
    end else begin
      src_reload <= 1'b0;
      dst_reload <= 1'b0;
      if (wr_en) begin
        case (wr_sel)
          3'd0: ctl <= wr_data[7:0];
          3'd1: begin
            s_start  <= wr_data[AW-1:0];
            src_addr <= wr_data[AW-1:0];
            src_left <= s_size;
          end
          3'd2: begin
            d_start  <= wr_data[AW-1:0];
            dst_addr <= wr_data[AW-1:0];
            dst_left <= d_size;
          end
          3'd3: begin
            s_size   <= wr_data[CW-1:0];
            src_addr <= s_start;
            src_left <= wr_data[CW-1:0];
          end
          3'd4: begin
            d_size   <= wr_data[CW-1:0];
            dst_addr <= d_start;
            dst_left <= wr_data[CW-1:0];
          end
          3'd5: trig_en <= wr_data[0];
          default: ;
        endcase
      end else if (go) begin
        if (s_wrap) begin
          src_addr   <= s_start;
          src_left   <= s_size;
          src_reload <= 1'b1;
        end else begin
          src_addr <= step(src_addr, s_mode);
          src_left <= src_left - ONE;
        end
        if (d_wrap) begin
          dst_addr   <= d_start;
          dst_left   <= d_size;
          dst_reload <= 1'b1;
        end else begin
          dst_addr <= step(dst_addr, d_mode);
          dst_left <= dst_left - ONE;
        end
        if ((s_wrap && s_stop) || (d_wrap && d_stop)) trig_en <= 1'b0;
      end
    end
  end

  assert_reload_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    src_reload |-> (src_addr == s_start && src_left == s_size));
  assert_dst_reload_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dst_reload |-> (dst_addr == d_start && dst_left == d_size));
  assert_flag_after_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_reload || dst_reload) |-> $past(xfer_done));
  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_reload && s_stop) || (dst_reload && d_stop)) |-> !trig_en);
  assert_hold_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !s_wrap && s_mode[0] == s_mode[1]) |=> $stable(src_addr));
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_en && !wr_en) |=> ($stable(src_addr) && $stable(dst_addr) &&
                              $stable(src_left) && $stable(dst_left) && !src_reload && !dst_reload));
  assert_region_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    src_region != 2'b11);

endmodule

// File: tb/sim_dma_addr_seq.sv
module sim_dma_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        xfer_done = 1'b0;
  logic [15:0] src_addr, dst_addr, src_left, dst_left;
  logic [1:0]  src_region;
  logic        src_reload, dst_reload, trig_en;

  dma_addr_seq u0 (.*);

  always #10 clk = ~clk;

  typedef struct packed {
    logic [15:0] sa, da, sl, dl;
    logic [1:0]  rg;
    logic        sr, dr, te;
  } exp_t;

  exp_t  q_exp[$];
  string q_tag[$];
  int checks = 0, fails = 0;
  logic done = 1'b0;

  logic [7:0]  m_ctl = '0;
  logic [15:0] m_ss = '0, m_ds = '0, m_sz = '0, m_dz = '0;
  logic [15:0] m_sp = '0, m_dp = '0, m_sc = '0, m_dc = '0;
  logic        m_te = 1'b0, m_sr = 1'b0, m_dr = 1'b0;

  function automatic logic [15:0] mv(input logic [15:0] p, input logic [1:0] m);
    if (m == 2'b01) return p + 16'd1;
    if (m == 2'b10) return p - 16'd1;
    return p;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic step(input logic we, input logic [2:0] sel, input logic [15:0] d,
                      input logic xd, input string tag);
    logic sw, dw;
    exp_t e;
    wr_en = we; wr_sel = sel; wr_data = d; xfer_done = xd;
    m_sr = 1'b0; m_dr = 1'b0;
    if (we) begin
      case (sel)
        3'd0: m_ctl = d[7:0];
        3'd1: begin m_ss = d; m_sp = d; m_sc = m_sz; end
        3'd2: begin m_ds = d; m_dp = d; m_dc = m_dz; end
        3'd3: begin m_sz = d; m_sp = m_ss; m_sc = d; end
        3'd4: begin m_dz = d; m_dp = m_ds; m_dc = d; end
        3'd5: m_te = d[0];
        default: ;
      endcase
    end else if (xd && m_te) begin
      sw = m_sc <= 16'd1;
      dw = m_dc <= 16'd1;
      if (sw) begin m_sp = m_ss; m_sc = m_sz; m_sr = 1'b1; end
      else begin m_sp = mv(m_sp, m_ctl[2:1]); m_sc = m_sc - 16'd1; end
      if (dw) begin m_dp = m_ds; m_dc = m_dz; m_dr = 1'b1; end
      else begin m_dp = mv(m_dp, m_ctl[7:6]); m_dc = m_dc - 16'd1; end
      if ((sw && m_ctl[0]) || (dw && m_ctl[5])) m_te = 1'b0;
    end
    e.sa = m_sp; e.da = m_dp; e.sl = m_sc; e.dl = m_dc;
    e.rg = m_ctl[4] ? 2'b10 : {1'b0, m_ctl[3]};
    e.sr = m_sr; e.dr = m_dr; e.te = m_te;
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (q_exp.size() != 0) begin
      exp_t e, a;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      a = {src_addr, dst_addr, src_left, dst_left, src_region, src_reload, dst_reload, trig_en};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: actual sa=%h da=%h sl=%0d dl=%0d rg=%b sr=%b dr=%b te=%b expected sa=%h da=%h sl=%0d dl=%0d rg=%b sr=%b dr=%b te=%b",
                 t, a.sa, a.da, a.sl, a.dl, a.rg, a.sr, a.dr, a.te,
                 e.sa, e.da, e.sl, e.dl, e.rg, e.sr, e.dr, e.te);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({src_addr, dst_addr, src_left, dst_left, src_region, src_reload, dst_reload, trig_en} !== '0) begin
      fails++;
      $display("FAIL R1: actual sa=%h da=%h te=%b expected all zero", src_addr, dst_addr, trig_en);
    end
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0, 0, 0, "R1 idle after reset");
    // R2: dst inc, dst stop 0, region 01, src dec, src stop 0
    step(1, 0, 16'h004C, 0, "R2 control write");
    step(1, 1, 16'h0001, 0, "R9 src start");
    step(1, 2, 16'hFFFE, 0, "R9 dst start");
    step(1, 3, 16'd3, 0, "R9 src size");
    step(1, 4, 16'd5, 0, "R9 dst size");
    step(0, 0, 0, 1, "R10 xfer while disabled");
    step(1, 5, 16'h0001, 0, "R9 trigger enable");
    step(0, 0, 0, 1, "R3 dec and inc");
    step(0, 0, 0, 1, "R4 wrap both sides");
    step(0, 0, 0, 1, "R5 src reload");
    step(0, 0, 0, 0, "R6 flag drops");
    step(0, 0, 0, 1, "R3 step after reload");
    step(1, 7, 16'h0000, 1, "R10 write blocks xfer");
    step(0, 0, 0, 1, "R5 dst reload R7 no stop");
    // R7/R3/R8: src stop on, src mode 11, dst hold, region 11
    step(1, 0, 16'h001F, 0, "R8 region 11");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, "R7 src stop R3 hold");
    step(0, 0, 0, 1, "R10 after stop");
    step(1, 0, 16'h0010, 0, "R8 region 10");
    step(1, 0, 16'h0000, 0, "R8 region 00");
    // R7: dst stop on, dst mode inc
    step(1, 0, 16'h0060, 0, "R2 dst stop bit");
    step(1, 4, 16'd2, 0, "R9 dst size reload");
    step(1, 5, 16'h0001, 0, "R9 enable again");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, "R7 dst stop");
    // R5: size 0 reloads each transfer
    step(1, 0, 16'h0000, 0, "R2 clear stops");
    step(1, 4, 16'd0, 0, "R9 dst size zero");
    step(1, 5, 16'h0001, 0, "R9 enable");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, "R5 size zero");
    step(0, 0, 0, 0, "R6 quiet");
    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule